// File: doc/BRIEF.md
# Striped Array Block Address Mapper

This block turns the logical block number of a host request into the physical place where that block lives in an array of `NDISK` disks. For each block it gives the disk that holds the data, the row (strip offset) on that disk, the stripe the block belongs to, and the disk that holds that stripe's parity. A two-bit layout code that comes with each request selects one of three layouts:
- plain striping with no redundancy;
- striping with the parity of every stripe kept on one fixed disk;
- striping with the parity disk rotating from stripe to stripe.

Division and modulo by the array width are done by a shared iterative unit that produces one quotient bit per cycle. So a request takes a number of cycles before its response appears, and a second division pass is needed in the rotating layout.

A separate accumulator folds a stream of data words into their bitwise XOR. It pulses a done flag once the word marked last has been absorbed, so the parity block for a stripe can be written. Requests use a valid/ready handshake. Only one request is outstanding at a time: a new request is taken only after the response to the previous one has been consumed.

Top module: `raid_map_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `par_done` is 0.
- R2: With layout code 0 (plain striping), block k maps as follows: `rsp_disk` = k mod N, `rsp_offset` = `rsp_stripe` = k div N, `rsp_par_en` = 0 and `rsp_par_disk` = 0.
- R3: With layout code 1 (fixed parity disk), each stripe holds N-1 data blocks. Block k maps as follows: `rsp_stripe` = `rsp_offset` = k div (N-1), `rsp_disk` = k mod (N-1), `rsp_par_disk` = N-1 and `rsp_par_en` = 1.
- R4: With layout code 2 (rotating parity), let s = k div (N-1). Then `rsp_stripe` = `rsp_offset` = s and `rsp_par_disk` = N-1-(s mod N). Block position p = k mod (N-1) is placed on the p-th non-parity disk in ascending order: disk p if p < parity disk, otherwise disk p+1. `rsp_par_en` = 1.
- R5: Layout code 3 maps exactly like code 0.
- R6: After a request is accepted, `req_ready` stays 0 until the response has been taken with `rsp_ready`. A request presented while `req_ready` is 0 is ignored and does not change the pending response.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay unchanged and `rsp_valid` stays 1.
- R8: `par_done` goes high in the cycle after a word with `par_last` = 1 is taken. At that point `par_out` equals the XOR of all words taken since the previous last word, including the last one.
- R9: After a last word the accumulator starts empty, so each stripe's parity depends only on its own words. Cycles with `par_valid` = 0 add nothing.
- R10: `rsp_disk` is always below N, and in the parity layouts it never equals `rsp_par_disk`.
- R11: The mapping holds up to the largest block number, 2^LBA_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_lba | input | LBA_W | Logical block number |
| req_mode | input | 2 | Layout code: 0 stripe, 1 fixed parity, 2 rotating parity, 3 as 0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_disk | output | DISK_W | Disk holding the data block |
| rsp_offset | output | LBA_W | Strip row on that disk |
| rsp_par_disk | output | DISK_W | Disk holding the stripe parity |
| rsp_par_en | output | 1 | Layout has parity |
| rsp_stripe | output | LBA_W | Stripe number |
| par_valid | input | 1 | Parity stream word present |
| par_data | input | DATA_W | Parity stream word |
| par_last | input | 1 | Last word of the stripe |
| par_out | output | DATA_W | XOR of the stripe's words |
| par_done | output | 1 | One-cycle pulse: `par_out` is fresh |

## Verification
The bench builds the block with N = 4, LBA_W = 16 and DATA_W = 32. With N = 4, the three data blocks per stripe and the four-stripe rotation make a full rotating-parity cycle every twelve blocks. This lets the directed sweep of blocks 0 to 23 reach every parity position twice, including the case where the parity sits on disk 0 and all data shifts up. The 16-bit block number makes the all-ones block reachable, so the divider's full iteration count and the largest quotient are exercised. Random requests mix all four layout codes, random response back-pressure and requests that arrive while the block is busy.

// File: rtl/raid_map_pkg.sv
// Shared types for the striped array mapper.
package raid_map_pkg;
    // Layout code carried with each request.
    typedef enum logic [1:0] {
        LAY_STRIPE = 2'd0,
        LAY_DEDIC  = 2'd1,
        LAY_ROTATE = 2'd2,
        LAY_RSVD   = 2'd3
    } layout_e;

    // Control states of the request sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV1 = 2'd1,
        ST_DIV2 = 2'd2,
        ST_RESP = 2'd3
    } seq_state_e;
endpackage

// File: rtl/raid_map_divider.sv
// Iterative restoring divider: one quotient bit per cycle.
// Assumes divisor is nonzero and start is only raised when idle;
// done pulses for one cycle QW cycles after start.
module raid_map_divider #(
    parameter int QW = 16,
    parameter int DV = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [QW-1:0] dividend,
    input  logic [DV-1:0] divisor,
    output logic          done,
    output logic [QW-1:0] quotient,
    output logic [DV-1:0] remainder
);
    localparam int CW = $clog2(QW + 1);

    logic [DV-1:0] rem_q;
    logic [QW-1:0] quo_q;
    logic [DV-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic [DV:0]   trial;
    logic [DV:0]   diff;
    logic          fits;

    // Shift in the next dividend bit and try a subtraction.
    always_comb begin
        trial = {rem_q, quo_q[QW-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    // Iteration registers: load on start, then one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CW'(QW);
            end else if (cnt_q != '0) begin
                rem_q <= fits ? diff[DV-1:0] : trial[DV-1:0];
                quo_q <= {quo_q[QW-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) done <= 1'b1;
            end
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;

    // R2/R3/R4: a finished division leaves a remainder below the divisor.
    a_r2_rem_lt_div: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remainder < dvs_q));
    // R6: the sequencer never restarts a division in flight.
    a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt_q == '0));
endmodule

// File: rtl/raid_map_layout.sv
// Combinational placement of a block inside its stripe.
// Inputs are the stripe position (block mod width) and, for the
// rotating layout, the stripe index mod NDISK. Parity layouts are
// only built when NDISK >= 3; below that they fall back to striping.
module raid_map_layout
    import raid_map_pkg::*;
#(
    parameter int NDISK  = 4,
    parameter int DV     = 3,
    parameter int DISK_W = 2
) (
    input  layout_e           mode,
    input  logic [DV-1:0]     pos,
    input  logic [DV-1:0]     rot,
    output logic [DISK_W-1:0] disk,
    output logic [DISK_W-1:0] par_disk,
    output logic              par_en
);
    localparam logic [DV-1:0] LAST = DV'(NDISK - 1);

    logic [DV-1:0] rot_pdisk;
    logic [DV-1:0] rot_disk;

    generate
        if (NDISK >= 3) begin : g_parity
            // Rotating parity: parity walks down one disk per stripe,
            // data skips over it in ascending order.
            always_comb begin
                rot_pdisk = LAST - rot;
                rot_disk  = (pos >= rot_pdisk) ? pos + DV'(1) : pos;
            end

            // Select the placement for the requested layout.
            always_comb begin
                unique case (mode)
                    LAY_DEDIC: begin
                        disk     = pos[DISK_W-1:0];
                        par_disk = LAST[DISK_W-1:0];
                        par_en   = 1'b1;
                    end
                    LAY_ROTATE: begin
                        disk     = rot_disk[DISK_W-1:0];
                        par_disk = rot_pdisk[DISK_W-1:0];
                        par_en   = 1'b1;
                    end
                    default: begin
                        disk     = pos[DISK_W-1:0];
                        par_disk = '0;
                        par_en   = 1'b0;
                    end
                endcase
            end
        end else begin : g_plain
            // Too few disks for parity: everything is plain striping.
            always_comb begin
                rot_pdisk = rot;
                rot_disk  = pos;
                disk      = pos[DISK_W-1:0];
                par_disk  = '0;
                par_en    = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/raid_map_parity.sv
// Streaming XOR accumulator for one stripe at a time.
// Words with valid are folded in; the word flagged last closes the
// stripe, publishes the result and clears the running value.
module raid_map_parity #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [DATA_W-1:0] out_par,
    output logic              out_done
);
    logic [DATA_W-1:0] acc_q;

    // Accumulate, and on the last word publish and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            out_par  <= '0;
            out_done <= 1'b0;
        end else begin
            out_done <= 1'b0;
            if (in_valid) begin
                if (in_last) begin
                    out_par  <= acc_q ^ in_data;
                    acc_q    <= '0;
                    out_done <= 1'b1;
                end else begin
                    acc_q <= acc_q ^ in_data;
                end
            end
        end
    end

    // R8: done only follows an accepted last word.
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid && in_last));
    // R9: a closed stripe leaves the accumulator empty.
    a_r9_restart_empty: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (acc_q == '0));
endmodule

// File: rtl/raid_map_top.sv
// Striped array block address mapper.
// Accepts one request at a time, divides the block number by the
// stripe width (and, for rotating parity, the stripe by NDISK) in a
// shared iterative divider, then presents the placement until taken.
// Assumes 2 <= NDISK <= 8; parity layouts need NDISK >= 3.
module raid_map_top
    import raid_map_pkg::*;
#(
    parameter int NDISK  = 4,
    parameter int LBA_W  = 16,
    parameter int DATA_W = 32,
    localparam int DISK_W = $clog2(NDISK),
    localparam int DV     = $clog2(NDISK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LBA_W-1:0]  req_lba,
    input  logic [1:0]        req_mode,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DISK_W-1:0] rsp_disk,
    output logic [LBA_W-1:0]  rsp_offset,
    output logic [DISK_W-1:0] rsp_par_disk,
    output logic              rsp_par_en,
    output logic [LBA_W-1:0]  rsp_stripe,
    input  logic              par_valid,
    input  logic [DATA_W-1:0] par_data,
    input  logic              par_last,
    output logic [DATA_W-1:0] par_out,
    output logic              par_done
);
    localparam logic [DV-1:0] W_PLAIN  = DV'(NDISK);
    localparam logic [DV-1:0] W_PARITY = DV'(NDISK - 1);
    localparam bit            HAS_PAR  = (NDISK >= 3);

    seq_state_e       state_q;
    layout_e          mode_q;
    layout_e          req_lay;
    logic [LBA_W-1:0] stripe_q;
    logic [DV-1:0]    pos_q;
    logic [DV-1:0]    rot_q;

    logic             div_start;
    logic [LBA_W-1:0] div_dividend;
    logic [DV-1:0]    div_divisor;
    logic             div_done;
    logic [LBA_W-1:0] div_quo;
    logic [DV-1:0]    div_rem;

    assign req_lay = layout_e'(req_mode);

    // Pick the divider operands for the current step.
    always_comb begin
        div_start    = 1'b0;
        div_dividend = req_lba;
        div_divisor  = W_PLAIN;
        if (state_q == ST_IDLE && req_valid) begin
            div_start = 1'b1;
            if (HAS_PAR && (req_lay == LAY_DEDIC || req_lay == LAY_ROTATE))
                div_divisor = W_PARITY;
        end else if (state_q == ST_DIV1 && div_done && HAS_PAR && mode_q == LAY_ROTATE) begin
            div_start    = 1'b1;
            div_dividend = div_quo;
            div_divisor  = W_PLAIN;
        end
    end

    // Request sequencer: accept, divide once or twice, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= LAY_STRIPE;
            stripe_q <= '0;
            pos_q    <= '0;
            rot_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    mode_q  <= req_lay;
                    state_q <= ST_DIV1;
                end
                ST_DIV1: if (div_done) begin
                    stripe_q <= div_quo;
                    pos_q    <= div_rem;
                    state_q  <= div_start ? ST_DIV2 : ST_RESP;
                end
                ST_DIV2: if (div_done) begin
                    rot_q   <= div_rem;
                    state_q <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    raid_map_divider #(.QW(LBA_W), .DV(DV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (div_dividend),
        .divisor   (div_divisor),
        .done      (div_done),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    raid_map_layout #(.NDISK(NDISK), .DV(DV), .DISK_W(DISK_W)) u_lay (
        .mode     (mode_q),
        .pos      (pos_q),
        .rot      (rot_q),
        .disk     (rsp_disk),
        .par_disk (rsp_par_disk),
        .par_en   (rsp_par_en)
    );

    raid_map_parity #(.DATA_W(DATA_W)) u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (par_valid),
        .in_data  (par_data),
        .in_last  (par_last),
        .out_par  (par_out),
        .out_done (par_done)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = (state_q == ST_RESP);
    assign rsp_offset = stripe_q;
    assign rsp_stripe = stripe_q;

    // R6: an accepted request blocks further requests and has no instant response.
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));
    // R7: a response waiting for the consumer does not move.
    a_r7_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_disk)
            && $stable(rsp_offset) && $stable(rsp_par_disk) && $stable(rsp_par_en)));
    // R10: data disk is inside the array.
    a_r10_disk_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (int'(rsp_disk) < NDISK));
    // R10: data never lands on the parity disk.
    a_r10_par_differs: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_par_en) |-> (rsp_disk != rsp_par_disk));
    // R3: the fixed layout keeps parity on the highest disk.
    a_r3_dedic_last_disk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && mode_q == LAY_DEDIC && HAS_PAR) |-> (int'(rsp_par_disk) == NDISK - 1));
endmodule

// File: tb/tb_raid_map_top.sv
module tb_raid_map_top;
    localparam int N      = 4;
    localparam int LBA_W  = 16;
    localparam int DATA_W = 32;
    localparam int DISK_W = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LBA_W-1:0]  req_lba = '0;
    logic [1:0]        req_mode = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [DISK_W-1:0] rsp_disk;
    logic [LBA_W-1:0]  rsp_offset;
    logic [DISK_W-1:0] rsp_par_disk;
    logic              rsp_par_en;
    logic [LBA_W-1:0]  rsp_stripe;
    logic              par_valid = 1'b0;
    logic [DATA_W-1:0] par_data = '0;
    logic              par_last = 1'b0;
    logic [DATA_W-1:0] par_out;
    logic              par_done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    raid_map_top #(.NDISK(N), .LBA_W(LBA_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lba(req_lba), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_disk(rsp_disk),
        .rsp_offset(rsp_offset), .rsp_par_disk(rsp_par_disk), .rsp_par_en(rsp_par_en),
        .rsp_stripe(rsp_stripe), .par_valid(par_valid), .par_data(par_data),
        .par_last(par_last), .par_out(par_out), .par_done(par_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected placement from the requirements (R2..R5).
    function automatic void expect_map(input int k, input int mode,
                                       output int disk, output int off,
                                       output int pd, output int pe);
        int w, s, p;
        if (mode == 1 || mode == 2) w = N - 1; else w = N;
        s = k / w;
        p = k % w;
        off = s;
        if (mode == 1) begin
            disk = p; pd = N - 1; pe = 1;
        end else if (mode == 2) begin
            pd = N - 1 - (s % N);
            disk = (p >= pd) ? p + 1 : p;
            pe = 1;
        end else begin
            disk = p; pd = 0; pe = 0;
        end
    endfunction

    function automatic string req_tag(input int mode);
        case (mode)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R2";
        endcase
    endfunction

    // One request through the handshake, with back-pressure and ignored traffic.
    task automatic do_req(input int k, input int mode, input int hold);
        int ed, eo, ep, ee;
        logic [DISK_W-1:0] d0;
        logic [LBA_W-1:0]  o0;
        string t;
        expect_map(k, mode, ed, eo, ep, ee);
        t = req_tag(mode);
        @(negedge clk);
        req_valid = 1'b1;
        req_lba   = LBA_W'(k);
        req_mode  = 2'(mode);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // R6: busy now; present junk that must be ignored.
        check(req_ready == 1'b0, "R6", "ready after accept", req_ready, 0);
        req_lba  = ~LBA_W'(k);
        req_mode = 2'(mode + 1);
        while (!rsp_valid) @(negedge clk);
        check(req_ready == 1'b0, "R6", "ready while rsp pending", req_ready, 0);
        check(int'(rsp_disk) == ed, t, "disk", rsp_disk, ed);
        check(int'(rsp_offset) == eo, t, "offset", rsp_offset, eo);
        check(int'(rsp_stripe) == eo, t, "stripe", rsp_stripe, eo);
        check(int'(rsp_par_disk) == ep, t, "par_disk", rsp_par_disk, ep);
        check(int'(rsp_par_en) == ee, t, "par_en", rsp_par_en, ee);
        check(int'(rsp_disk) < N && (ee == 0 || rsp_disk != rsp_par_disk),
              "R10", "disk range/overlap", rsp_disk, ed);
        d0 = rsp_disk;
        o0 = rsp_offset;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_disk == d0 && rsp_offset == o0, "R7",
                  "held response", rsp_offset, o0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid == 1'b0, "R6", "rsp_valid after consume", rsp_valid, 0);
        check(req_ready == 1'b1, "R6", "ready after consume", req_ready, 1);
    endtask

    // Stream one stripe of words into the parity unit and check it (R8, R9).
    task automatic do_parity(input int len, input bit gaps);
        logic [DATA_W-1:0] x = '0;
        logic [DATA_W-1:0] w;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && i > 0) begin
                par_valid = 1'b0;
                par_data  = $urandom;
                @(negedge clk);
            end
            w = $urandom;
            x ^= w;
            par_valid = 1'b1;
            par_data  = w;
            par_last  = (i == len - 1);
        end
        @(negedge clk);
        par_valid = 1'b0;
        par_last  = 1'b0;
        check(par_done == 1'b1, "R8", "done pulse", par_done, 1);
        check(par_out == x, gaps ? "R9" : "R8", "parity value", par_out, x);
        @(negedge clk);
        check(par_done == 1'b0, "R8", "done is one cycle", par_done, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        check(par_done == 1'b0, "R1", "par_done", par_done, 0);

        // Directed sweep covering two full rotations, all layouts.
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 24; k++)
                do_req(k, m, 0);
        // R11: largest block number in every layout.
        for (int m = 0; m < 4; m++)
            do_req((1 << LBA_W) - 1, m, 1);

        // Constrained random mix.
        for (int i = 0; i < 300; i++)
            do_req(int'($urandom_range((1 << LBA_W) - 1, 0)),
                   int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));

        // Parity stream: single word, long stripes, gaps, back-to-back stripes.
        do_parity(1, 0);
        do_parity(3, 0);
        for (int i = 0; i < 20; i++)
            do_parity(int'($urandom_range(6, 1)), bit'($urandom_range(1, 0)));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule